// File: doc/BRIEF.md
# Alternating-Pair Ridge/Valley Column Rebuilder

This block turns two sets of relative comparator codes for one sensor column into an absolute one-bit image of that column. A column has `ROWS` cells arranged as a closed ring. The first code set compares cells 2k and 2k+1. The second set compares cells 2k+1 and 2k+2, and its last code closes the ring by comparing the top cell with cell 0. Together the two sets give one code for every adjacent pair of cells around the ring. No code gives an absolute level, so the block picks an anchor, which is a pair whose code shows a transition, and fixes the absolute value from it.

A request presents both code sets and raises `start` for one cycle. The block latches the codes and looks for the anchor. It then walks the ring one cell per clock. Each step fills in the next cell and checks that cell against its code. The last step checks the pair that closes the ring. When the walk ends, `done` pulses and the image and the two flags are valid. They stay valid until the next accepted request. A column with no transition cannot be resolved, so it is reported as ambiguous. A column whose codes are illegal or disagree with each other is reported as an error.

Top module: `fp_ridge_rebuild`

## Requirements
- R1: Ring edge e (0 ≤ e < ROWS) relates cell e to cell (e+1) mod ROWS. Even e takes `p1_codes[2*(e/2)+1 : 2*(e/2)]`. Odd e takes `p2_codes[2*((e-1)/2)+1 : 2*((e-1)/2)]`. So the top code of `p2_codes` relates cell ROWS−1 to cell 0.
- R2: An edge code means: 2'b00 = both cells equal, 2'b01 = first cell valley and second ridge, 2'b10 = first ridge and second valley. In `image`, bit i is 1 for a ridge and 0 for a valley.
- R3: When the codes are consistent and at least one is nonzero, `image` equals the unique column whose edge codes match every input code, and both `ambiguous` and `error_flag` are 0.
- R4: When every code is 2'b00, `image` is all zeros, `ambiguous` is 1 and `error_flag` is 0.
- R5: When any code is 2'b11, `error_flag` is 1.
- R6: When no code is 2'b11 but no column satisfies every code (for example, counts of 01 and 10 differ), `error_flag` is 1.
- R7: `done` is a one-cycle pulse. Counting the rising edge that samples `start` as edge 1, `done` is high after edge ROWS+1 for a column with a transition and after edge 2 for an all-zero column.
- R8: `start` and the code inputs are ignored from the accepting edge until `done`. The result reflects the codes latched when the request was accepted.
- R9: `image`, `ambiguous` and `error_flag` hold their values from `done` until the next accepted `start`, whatever the code inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted when idle |
| p1_codes | input | ROWS | First code set, two bits per even-starting pair |
| p2_codes | input | ROWS | Second code set, two bits per odd-starting pair, last one wrapping |
| done | output | 1 | One-cycle completion pulse |
| image | output | ROWS | Rebuilt column, 1 = ridge |
| ambiguous | output | 1 | Column had no transition |
| error_flag | output | 1 | Illegal or contradictory codes |

## Verification
The bench targets columns whose only transitions sit on the wrapping edge or on the top phase-one pair. A design that got the ring wrap wrong would return an inverted or shifted image for these. It also runs a uniform all-ridge column, which must come back as all valley and ambiguous. A design that trusted an absolute level would return ones here. Single-edge corruptions of consistent codes must raise the error flag. A walk that skipped the closing-edge check would miss these, because a single flipped edge shows up only on closing the ring. The bench also changes inputs and pulses `start` during a walk, which exposes a design that does not latch its codes.

// File: rtl/fp_recon_pkg.sv
package fp_recon_pkg;

    typedef enum logic [1:0] {
        PAIR_SAME = 2'b00,
        PAIR_VR   = 2'b01,
        PAIR_RV   = 2'b10,
        PAIR_BAD  = 2'b11
    } pair_code_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEEK,
        ST_WALK
    } rb_state_t;

    typedef struct packed {
        logic ambiguous;
        logic error;
    } col_flags_t;

    // value of the second cell of a pair given the first and the code
    function automatic logic next_cell(pair_code_t c, logic pred);
        return (c == PAIR_SAME) ? pred : (c == PAIR_VR);
    endfunction

    // true when the first cell disagrees with what the code claims
    function automatic logic pred_bad(pair_code_t c, logic pred);
        return (c == PAIR_BAD) || (c == PAIR_VR && pred) || (c == PAIR_RV && !pred);
    endfunction

    // code that a pair of known cells would produce
    function automatic pair_code_t code_of(logic a, logic b);
        if (a == b) return PAIR_SAME;
        return a ? PAIR_RV : PAIR_VR;
    endfunction

endpackage

// File: rtl/fp_edge_ring.sv
module fp_edge_ring #(
    parameter int ROWS = 16
) (
    input  logic [ROWS-1:0]      p1_codes,
    input  logic [ROWS-1:0]      p2_codes,
    output logic [ROWS-1:0][1:0] edges
);
    for (genvar e = 0; e < ROWS; e++) begin : g_edge
        if (e % 2 == 0) begin : g_even
            assign edges[e] = p1_codes[2*(e/2) +: 2];
        end else begin : g_odd
            assign edges[e] = p2_codes[2*((e-1)/2) +: 2];
        end
    end
endmodule

// File: rtl/fp_anchor_find.sv
module fp_anchor_find #(
    parameter int ROWS = 16,
    localparam int IDXW = $clog2(ROWS)
) (
    input  logic [ROWS-1:0][1:0] edges,
    output logic                 found,
    output logic [IDXW-1:0]      idx,
    output logic                 illegal
);
    always_comb begin
        found   = 1'b0;
        idx     = '0;
        illegal = 1'b0;
        for (int e = ROWS - 1; e >= 0; e--) begin
            if (edges[e] != 2'b00) begin
                found = 1'b1;
                idx   = IDXW'(e);
            end
            if (edges[e] == 2'b11) illegal = 1'b1;
        end
    end
endmodule

// File: rtl/fp_ridge_rebuild.sv
module fp_ridge_rebuild
    import fp_recon_pkg::*;
#(
    parameter int ROWS = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [ROWS-1:0] p1_codes,
    input  logic [ROWS-1:0] p2_codes,
    output logic            done,
    output logic [ROWS-1:0] image,
    output logic            ambiguous,
    output logic            error_flag
);
    localparam int IDXW = $clog2(ROWS);
    localparam logic [IDXW-1:0] LAST = IDXW'(ROWS - 1);

    rb_state_t             state_q;
    logic [ROWS-1:0][1:0]  edges_in, edges_q;
    logic [ROWS-1:0]       img_q, anchor_img;
    logic [IDXW-1:0]       cur_q, cur_nxt, anc_idx, anc_nxt, steps_q;
    col_flags_t            flags_q;
    logic                  done_q, anc_found, anc_illegal;
    pair_code_t            anc_code, walk_code;
    logic                  walk_pred, walk_val;

    fp_edge_ring #(.ROWS(ROWS)) u_ring (
        .p1_codes (p1_codes),
        .p2_codes (p2_codes),
        .edges    (edges_in)
    );

    fp_anchor_find #(.ROWS(ROWS)) u_anchor (
        .edges   (edges_q),
        .found   (anc_found),
        .idx     (anc_idx),
        .illegal (anc_illegal)
    );

    always_comb begin
        anc_nxt    = (anc_idx == LAST) ? '0 : anc_idx + 1'b1;
        cur_nxt    = (cur_q == LAST) ? '0 : cur_q + 1'b1;
        anc_code   = pair_code_t'(edges_q[anc_idx]);
        anchor_img = '0;
        anchor_img[anc_idx] = (anc_code == PAIR_RV);
        anchor_img[anc_nxt] = (anc_code != PAIR_RV);
        walk_code  = pair_code_t'(edges_q[cur_q]);
        walk_pred  = img_q[cur_q];
        walk_val   = next_cell(walk_code, walk_pred);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            edges_q <= '0;
            img_q   <= '0;
            cur_q   <= '0;
            steps_q <= '0;
            flags_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        edges_q <= edges_in;
                        state_q <= ST_SEEK;
                    end
                end
                ST_SEEK: begin
                    if (!anc_found) begin
                        img_q   <= '0;
                        flags_q <= '{ambiguous: 1'b1, error: 1'b0};
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        img_q   <= anchor_img;
                        cur_q   <= anc_nxt;
                        steps_q <= LAST;
                        flags_q <= '{ambiguous: 1'b0, error: anc_illegal};
                        state_q <= ST_WALK;
                    end
                end
                ST_WALK: begin
                    if (steps_q != IDXW'(1)) begin
                        img_q[cur_nxt] <= walk_val;
                    end else begin
                        if (img_q[cur_nxt] != walk_val) flags_q.error <= 1'b1;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                    if (pred_bad(walk_code, walk_pred)) flags_q.error <= 1'b1;
                    cur_q   <= cur_nxt;
                    steps_q <= steps_q - 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done       = done_q;
    assign image      = img_q;
    assign ambiguous  = flags_q.ambiguous;
    assign error_flag = flags_q.error;

endmodule

// File: rtl/fp_ridge_rebuild_chk.sv
module fp_ridge_rebuild_chk
    import fp_recon_pkg::*;
#(
    parameter int ROWS = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic [ROWS-1:0] p1_codes,
    input logic [ROWS-1:0] p2_codes,
    input logic            done,
    input logic [ROWS-1:0] image,
    input logic            ambiguous,
    input logic            error_flag
);
    localparam int CW = $clog2(ROWS) + 2;

    logic [ROWS-1:0][1:0] live_edges, cap_q;
    logic                 busy_q, accept, all_ok;
    logic [CW-1:0]        cnt_q;

    for (genvar e = 0; e < ROWS; e++) begin : g_map
        if (e % 2 == 0) begin : g_a
            assign live_edges[e] = p1_codes[2*(e/2) +: 2];
        end else begin : g_b
            assign live_edges[e] = p2_codes[2*((e-1)/2) +: 2];
        end
    end

    assign accept = start && (!busy_q || done);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            cap_q  <= '0;
        end else begin
            if (done) busy_q <= 1'b0;
            if (accept) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
                cap_q  <= live_edges;
            end else if (busy_q) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        all_ok = 1'b1;
        for (int e = 0; e < ROWS; e++) begin
            if (code_of(image[e], image[(e + 1) % ROWS]) != pair_code_t'(cap_q[e]))
                all_ok = 1'b0;
        end
    end

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_busy_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> busy_q);
    assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q <= CW'(ROWS + 1)));
    assert_amb_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (done && ambiguous) |-> (image == '0 && !error_flag));
    assert_consistent_R3: assert property (@(posedge clk) disable iff (rst)
        (done && !ambiguous && !error_flag) |-> all_ok);
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && !start) |=> ($stable(image) && $stable(ambiguous) && $stable(error_flag)));

endmodule

bind fp_ridge_rebuild fp_ridge_rebuild_chk #(.ROWS(ROWS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .p1_codes   (p1_codes),
    .p2_codes   (p2_codes),
    .done       (done),
    .image      (image),
    .ambiguous  (ambiguous),
    .error_flag (error_flag)
);

// File: tb/tb_fp_ridge_rebuild.sv
module tb_fp_ridge_rebuild;
    localparam int ROWS = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [ROWS-1:0] p1 = '0, p2 = '0;
    logic            done, ambiguous, error_flag;
    logic [ROWS-1:0] image;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    fp_ridge_rebuild #(.ROWS(ROWS)) dut (
        .clk(clk), .rst(rst), .start(start), .p1_codes(p1), .p2_codes(p2),
        .done(done), .image(image), .ambiguous(ambiguous), .error_flag(error_flag)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R1/R2: code of each ring edge placed in its phase set
    function automatic logic [2*ROWS-1:0] codes_of(input logic [ROWS-1:0] img);
        logic [ROWS-1:0] a = '0, b = '0;
        for (int e = 0; e < ROWS; e++) begin
            logic x, y;
            logic [1:0] c;
            x = img[e];
            y = img[(e + 1) % ROWS];
            c = (x == y) ? 2'b00 : (x ? 2'b10 : 2'b01);
            if (e % 2 == 0) a[2*(e/2) +: 2] = c;
            else            b[2*((e-1)/2) +: 2] = c;
        end
        return {b, a};
    endfunction

    function automatic logic [1:0] get_edge(input logic [2*ROWS-1:0] cc, input int e);
        return (e % 2 == 0) ? cc[2*(e/2) +: 2] : cc[ROWS + 2*((e-1)/2) +: 2];
    endfunction

    function automatic logic [2*ROWS-1:0] set_edge(input logic [2*ROWS-1:0] cc, input int e, input logic [1:0] v);
        logic [2*ROWS-1:0] r = cc;
        if (e % 2 == 0) r[2*(e/2) +: 2] = v;
        else            r[ROWS + 2*((e-1)/2) +: 2] = v;
        return r;
    endfunction

    task automatic run_col(input logic [2*ROWS-1:0] cc, output int lat);
        @(negedge clk);
        p1 = cc[ROWS-1:0];
        p2 = cc[2*ROWS-1:ROWS];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic good_col(input logic [ROWS-1:0] img, input string req);
        int lat;
        bit uni;
        uni = (img == '0) || (img == '1);
        run_col(codes_of(img), lat);
        if (uni) begin
            chk(lat == 2, "R7 latency uniform", lat, 2);
            chk(image == '0, {"R4 image ", req}, image, 0);
            chk(ambiguous && !error_flag, {"R4 flags ", req}, {ambiguous, error_flag}, 2'b10);
        end else begin
            chk(lat == ROWS + 1, "R7 latency", lat, ROWS + 1);
            chk(image == img, {"R3 image ", req}, image, img);
            chk(!ambiguous && !error_flag, {"R3 flags ", req}, {ambiguous, error_flag}, 0);
        end
        @(negedge clk);
        chk(!done, "R7 done single pulse", done, 0);
    endtask

    task automatic bad_col(input logic [2*ROWS-1:0] cc, input string req);
        int lat;
        run_col(cc, lat);
        chk(error_flag, req, error_flag, 1);
    endtask

    initial begin
        logic [ROWS-1:0] img, held;
        logic [2*ROWS-1:0] cc;
        int e, lat;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && image == '0 && !ambiguous && !error_flag, "reset state", {done, ambiguous, error_flag}, 0);

        // directed corners
        good_col(16'h8000, "R1 lone ridge at top row");
        good_col(16'h8001, "R1 ridge pair across wrap");
        good_col(16'h7FFE, "R1 valley pair across wrap");
        good_col(16'hAAAA, "R2 alternating");
        good_col(16'h0006, "R2 paired ridges");
        good_col(16'h0000, "R4 all valley");
        good_col(16'hFFFF, "R4 all ridge");
        bad_col(set_edge(codes_of(16'h00F0), 15, 2'b11), "R5 code 11 on wrap edge");
        bad_col(set_edge('0, 3, 2'b01), "R6 lone transition");
        bad_col(set_edge(codes_of(16'h0001), 0, 2'b01), "R6 flipped direction");

        // R8: mid-walk disturbance
        img = 16'h3C5A;
        run_col(codes_of(img), lat);
        chk(image == img, "R8 baseline", image, img);
        @(negedge clk);
        p1 = codes_of(16'h0F0F)[ROWS-1:0];
        p2 = codes_of(16'h0F0F)[2*ROWS-1:ROWS];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            p1 = $urandom;
            p2 = $urandom;
            start = (i == 1);
        end
        start = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin @(negedge clk); lat++; end
        chk(image == 16'h0F0F && !error_flag, "R8 latched codes", image, 16'h0F0F);

        // R9: hold after done
        held = image;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            p1 = $urandom;
            p2 = $urandom;
        end
        chk(image == held && !ambiguous && !error_flag, "R9 hold", image, held);

        // random consistent columns
        for (int n = 0; n < 200; n++) begin
            img = ROWS'($urandom);
            if (n % 17 == 0) img = ROWS'(1) << ($urandom % ROWS);
            good_col(img, "R3 random");
        end

        // random single-edge corruption
        for (int n = 0; n < 60; n++) begin
            img = ROWS'($urandom);
            cc = codes_of(img);
            e = $urandom % ROWS;
            case (get_edge(cc, e))
                2'b00:   cc = set_edge(cc, e, ($urandom % 2) ? 2'b01 : 2'b10);
                2'b01:   cc = set_edge(cc, e, 2'b10);
                default: cc = set_edge(cc, e, 2'b01);
            endcase
            bad_col(cc, "R6 random contradiction");
        end
        for (int n = 0; n < 30; n++) begin
            cc = set_edge(codes_of(ROWS'($urandom)), $urandom % ROWS, 2'b11);
            bad_col(cc, "R5 random code 11");
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule